// File: doc/BRIEF.md
# Video RAM Transfer-Cycle Controller

This block models the row-transfer part of a dual-port video memory. The memory has a DRAM array of rows, each with a fixed number of columns, and a serial row buffer (SAM) that is one row wide. Each storage location holds a 4-bit word.

A cycle opens when the active-low row strobe falls. At that point the block captures four levels and the row address:

- `trg_n` decides whether the cycle is a transfer at all.
- `we_n` picks the direction.
- `dsf` and `se_n` pick the variant.

When the column strobe later falls, the address bus is captured as the tap point, which is the start position of the next serial access. One clock later the decoded transfer is carried out, and `xfer_done` pulses. The transfer is one of three things:

- a whole SAM row is written into the array;
- a whole array row is loaded into the SAM;
- only the serial-port direction changes.

Serial shifting is not modelled. It appears only as the tap pointer and the direction output, plus a load port that fills SAM entries and two probe ports that read SAM and array words back. Row and column counts are parameters. The address widths are derived from them.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: After reset `ser_in_mode` is 0 (serial output), `tap_ptr` is 0, `xfer_done` is 0, and every SAM and array word reads 0.
- R2: A cycle with `trg_n` high at the row-strobe fall is not a transfer. It raises no `xfer_done` and leaves the SAM, the array, `ser_in_mode` and `tap_ptr` unchanged.
- R3: Timing of `xfer_done`:
  - Suppose a clock edge is the first to see `cas_n` low after seeing it high, while `ras_n` is low in a transfer cycle.
  - Then `xfer_done` is high after the next clock edge, and for that one cycle only.
- R4: A normal write (`we_n`=0, `dsf`=0, `se_n`=0) copies every SAM word into the array row given by the low row-address bits captured at the row-strobe fall.
- R5: An alternate write (`we_n`=0, `dsf`=1) copies the whole SAM into the selected row whatever the level of `se_n`.
- R6: A pseudo write (`we_n`=0, `dsf`=0, `se_n`=1) moves no data. The row address has no effect, and the SAM and array keep their contents.
- R7: After any write-kind transfer, the pseudo write included, `ser_in_mode` is 1 (serial input).
- R8: A normal read (`we_n`=1, `dsf`=0) loads the selected array row into the SAM and sets `ser_in_mode` to 0.
- R9: A split read (`we_n`=1, `dsf`=1) also loads the selected row into the SAM, sets `ser_in_mode` to 0, and reloads the tap pointer.
- R10: On every transfer kind, `tap_ptr` takes the low column-address bits captured at the column-strobe fall.
- R11: Only the first column-strobe fall within one row-strobe low period triggers a transfer. Later falls in the same period change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, sampled on clk |
| cas_n | input | 1 | Column strobe, active low, sampled on clk |
| trg_n | input | 1 | Transfer select, low makes a transfer cycle |
| we_n | input | 1 | Low selects write transfer, high selects read |
| dsf | input | 1 | Variant select (alternate write, split read) |
| se_n | input | 1 | High with dsf low turns a write into a pseudo write |
| addr | input | AW | Multiplexed row / column address |
| sam_ld_en | input | 1 | Writes one SAM word (stands in for serial input) |
| sam_ld_idx | input | COLW | SAM word index for the load |
| sam_ld_data | input | DW | SAM word data for the load |
| sam_rd_idx | input | COLW | SAM probe index |
| sam_rd_data | output | DW | SAM word at the probe index |
| arr_rd_row | input | ROWW | Array probe row |
| arr_rd_col | input | COLW | Array probe column |
| arr_rd_data | output | DW | Array word at the probe position |
| ser_in_mode | output | 1 | Serial-port direction, 1 input, 0 output |
| tap_ptr | output | COLW | Tap pointer for the next serial access |
| xfer_done | output | 1 | One-cycle pulse when a transfer is carried out |

## Verification
The hardest situation to reach from the ports is showing that a pseudo write really ignores the row address. It has to follow earlier writes that left distinct data in several rows, while the SAM holds data different from the addressed row, or a wrong copy would go unseen.

The random stimulus reaches this state in three steps:
- it reloads random SAM words before each cycle;
- it mixes every control combination, including cycles with `trg_n` high, so that rows fill with distinct data;
- it then compares the whole SAM and array against a bench model after every cycle.

A directed case adds a second column-strobe fall within one row-strobe period, using a different column.

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl #(
  parameter int ROWS = 8,
  parameter int COLS = 16,
  parameter int DW   = 4,
  localparam int ROWW = $clog2(ROWS),
  localparam int COLW = $clog2(COLS),
  localparam int AW   = (ROWW > COLW) ? ROWW : COLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            trg_n,
  input  logic            we_n,
  input  logic            dsf,
  input  logic            se_n,
  input  logic [AW-1:0]   addr,
  input  logic            sam_ld_en,
  input  logic [COLW-1:0] sam_ld_idx,
  input  logic [DW-1:0]   sam_ld_data,
  input  logic [COLW-1:0] sam_rd_idx,
  output logic [DW-1:0]   sam_rd_data,
  input  logic [ROWW-1:0] arr_rd_row,
  input  logic [COLW-1:0] arr_rd_col,
  output logic [DW-1:0]   arr_rd_data,
  output logic            ser_in_mode,
  output logic [COLW-1:0] tap_ptr,
  output logic            xfer_done
);

  logic [DW-1:0] sam [COLS];
  logic [DW-1:0] arr [ROWS][COLS];

  logic            ras_q, cas_q;
  logic            armed, pend;
  logic            wr_q, pseudo_q;
  logic [ROWW-1:0] row_q;
  logic [COLW-1:0] col_q;

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n & ~ras_n;

  assign sam_rd_data = sam[sam_rd_idx];
  assign arr_rd_data = arr[arr_rd_row][arr_rd_col];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q       <= 1'b1;
      cas_q       <= 1'b1;
      armed       <= 1'b0;
      pend        <= 1'b0;
      wr_q        <= 1'b0;
      pseudo_q    <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      ser_in_mode <= 1'b0;
      tap_ptr     <= '0;
      xfer_done   <= 1'b0;
      for (int c = 0; c < COLS; c++) begin
        sam[c] <= '0;
        for (int r = 0; r < ROWS; r++) arr[r][c] <= '0;
      end
    end else begin
      ras_q     <= ras_n;
      cas_q     <= cas_n;
      xfer_done <= 1'b0;

      if (sam_ld_en) sam[sam_ld_idx] <= sam_ld_data;

      if (ras_fall) begin
        armed    <= ~trg_n;
        wr_q     <= ~we_n;
        pseudo_q <= ~we_n & ~dsf & se_n;
        row_q    <= addr[ROWW-1:0];
      end else if (ras_rise) begin
        armed <= 1'b0;
      end

      if (armed && cas_fall) begin
        col_q <= addr[COLW-1:0];
        pend  <= 1'b1;
        armed <= 1'b0;
      end

      if (pend) begin
        pend        <= 1'b0;
        xfer_done   <= 1'b1;
        tap_ptr     <= col_q;
        ser_in_mode <= wr_q;
        for (int c = 0; c < COLS; c++) begin
          if (wr_q && !pseudo_q) arr[row_q][c] <= sam[c];
          if (!wr_q)             sam[c]        <= arr[row_q][c];
        end
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R3
  AST_MODE_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |-> $stable(ser_in_mode)); // R2
  AST_TAP_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |-> $stable(tap_ptr)); // R10
  AST_WRITE_SETS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && wr_q) |-> ser_in_mode); // R7
  AST_READ_SETS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr_q) |-> !ser_in_mode); // R8
  AST_DONE_NEEDS_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_done) |-> !$past(cas_n, 2)); // R11

endmodule

// File: tb/vram_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module vram_xfer_ctrl_tb;
  localparam int ROWS = 8, COLS = 16, DW = 4;
  localparam int ROWW = $clog2(ROWS), COLW = $clog2(COLS);
  localparam int AW = (ROWW > COLW) ? ROWW : COLW;

  logic clk = 0, rst_n = 0;
  logic ras_n = 1, cas_n = 1, trg_n = 1, we_n = 1, dsf = 0, se_n = 0;
  logic [AW-1:0] addr = '0;
  logic sam_ld_en = 0;
  logic [COLW-1:0] sam_ld_idx = '0, sam_rd_idx = '0, arr_rd_col = '0;
  logic [DW-1:0] sam_ld_data = '0;
  logic [ROWW-1:0] arr_rd_row = '0;
  logic [DW-1:0] sam_rd_data, arr_rd_data;
  logic ser_in_mode, xfer_done;
  logic [COLW-1:0] tap_ptr;

  int tests = 0, fails = 0;
  logic [DW-1:0] exp_sam [COLS];
  logic [DW-1:0] exp_arr [ROWS][COLS];
  logic exp_mode;
  logic [COLW-1:0] exp_tap;

  always #4 clk = ~clk;

  vram_xfer_ctrl #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .trg_n(trg_n),
    .we_n(we_n), .dsf(dsf), .se_n(se_n), .addr(addr),
    .sam_ld_en(sam_ld_en), .sam_ld_idx(sam_ld_idx), .sam_ld_data(sam_ld_data),
    .sam_rd_idx(sam_rd_idx), .sam_rd_data(sam_rd_data),
    .arr_rd_row(arr_rd_row), .arr_rd_col(arr_rd_col), .arr_rd_data(arr_rd_data),
    .ser_in_mode(ser_in_mode), .tap_ptr(tap_ptr), .xfer_done(xfer_done));

  task automatic check(string tag, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic check_mem(string tag);
    int bad = 0, a = 0, e = 0;
    for (int c = 0; c < COLS; c++) begin
      sam_rd_idx = c[COLW-1:0];
      #0.1;
      if (sam_rd_data != exp_sam[c] && bad == 0) begin a = sam_rd_data; e = exp_sam[c]; end
      if (sam_rd_data != exp_sam[c]) bad++;
      for (int r = 0; r < ROWS; r++) begin
        arr_rd_row = r[ROWW-1:0]; arr_rd_col = c[COLW-1:0];
        #0.1;
        if (arr_rd_data != exp_arr[r][c] && bad == 0) begin a = arr_rd_data; e = exp_arr[r][c]; end
        if (arr_rd_data != exp_arr[r][c]) bad++;
      end
    end
    check({tag, " memory word"}, a, e);
    check({tag, " memory mismatch count"}, bad, 0);
  endtask

  task automatic load_sam(int idx, int data);
    @(negedge clk);
    sam_ld_en = 1; sam_ld_idx = idx[COLW-1:0]; sam_ld_data = data[DW-1:0];
    @(negedge clk);
    sam_ld_en = 0;
    exp_sam[idx] = data[DW-1:0];
  endtask

  task automatic run_cycle(bit trg, bit we, bit d, bit se, int row, int col, bit twice);
    string tag;
    if (trg) tag = "R2 non-transfer";
    else if (!we && d) tag = "R5 alternate write";
    else if (!we && se) tag = "R6 pseudo write";
    else if (!we) tag = "R4 normal write";
    else if (d) tag = "R9 split read";
    else tag = "R8 normal read";
    @(negedge clk);
    trg_n = trg; we_n = we; dsf = d; se_n = se; addr = row[AW-1:0];
    @(negedge clk); ras_n = 0;
    @(negedge clk); trg_n = 1; we_n = ~we; dsf = ~d; se_n = ~se;
    @(negedge clk); addr = col[AW-1:0];
    @(negedge clk); cas_n = 0;
    @(negedge clk); check({tag, " R3 done early"}, xfer_done, 0);
    @(negedge clk); check({tag, " R3 done pulse"}, xfer_done, !trg);
    if (!trg) begin
      exp_tap = col[COLW-1:0];
      if (!we) begin
        exp_mode = 1;
        if (d || !se) for (int c = 0; c < COLS; c++) exp_arr[row][c] = exp_sam[c];
      end else begin
        exp_mode = 0;
        for (int c = 0; c < COLS; c++) exp_sam[c] = exp_arr[row][c];
      end
    end
    @(negedge clk); check({tag, " R3 done drops"}, xfer_done, 0);
    if (twice) begin
      cas_n = 1; addr = (col ^ 5) & (COLS - 1);
      @(negedge clk); cas_n = 0;
      @(negedge clk); @(negedge clk);
      check("R11 second CAS fall done", xfer_done, 0);
      @(negedge clk);
      check("R11 second CAS fall tap", tap_ptr, exp_tap);
    end
    ras_n = 1; cas_n = 1;
    @(negedge clk); @(negedge clk);
    check({tag, " R7/R8 mode"}, ser_in_mode, exp_mode);
    check({tag, " R10 tap"}, tap_ptr, exp_tap);
    check_mem(tag);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < COLS; c++) begin
      exp_sam[c] = '0;
      for (int r = 0; r < ROWS; r++) exp_arr[r][c] = '0;
    end
    exp_mode = 0; exp_tap = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset mode", ser_in_mode, 0);
    check("R1 reset tap", tap_ptr, 0);
    check("R1 reset done", xfer_done, 0);
    check_mem("R1 reset");

    for (int c = 0; c < COLS; c++) load_sam(c, $urandom_range(15));
    run_cycle(0, 0, 0, 0, 3, 7, 0);            // R4
    for (int c = 0; c < COLS; c++) load_sam(c, $urandom_range(15));
    run_cycle(0, 0, 1, 1, 5, 2, 0);            // R5 with se_n high
    for (int c = 0; c < COLS; c++) load_sam(c, $urandom_range(15));
    run_cycle(0, 0, 0, 1, 3, 15, 0);           // R6 row 3 holds other data
    run_cycle(0, 1, 0, 0, 3, 0, 0);            // R8
    run_cycle(0, 1, 1, 0, 5, 9, 1);            // R9 plus R11
    run_cycle(1, 0, 0, 0, 5, 4, 0);            // R2 write-looking
    run_cycle(1, 1, 0, 0, 3, 11, 0);           // R2 read-looking

    for (int i = 0; i < 60; i++) begin
      int n = $urandom_range(4);
      for (int k = 0; k < n; k++) load_sam($urandom_range(COLS - 1), $urandom_range(15));
      run_cycle(($urandom_range(4) == 0), $urandom_range(1), $urandom_range(1),
                $urandom_range(1), $urandom_range(ROWS - 1), $urandom_range(COLS - 1),
                ($urandom_range(7) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule